// File: doc/BRIEF.md
# Two-Port GPIO Register Bank

This block holds the registers behind sixteen general-purpose pins, arranged as two byte-wide ports. For each port it keeps a direction byte, an output latch, a polarity mask and a captured copy of the input pins. A host reaches these registers over a narrow byte interface: a write strobe, a read strobe, a 3-bit register index, a write byte and a registered read byte. The serial bus front end that would drive this interface sits outside the block. The pad drivers, pull-ups and drive strength are also outside.

The block drives a per-pin output enable and output value toward the pads. It samples the sixteen pin levels through a two-flop synchronizer. When a port's input register is read, it captures that port's synchronized pin byte and hands the captured bytes to a separate change-detect interrupt block. Input data read back through the interface is XORed with the polarity mask. Reading an output register returns the latch contents, not the pin level.

Top module: `gpio_bank`

## Requirements
- R1: After reset, both direction registers read 0xFF, both output registers read 0xFF, both polarity registers read 0x00, `pin_oe` is all zero, `pin_out` is all zero and `rd_data` is 0x00.
- R2: The index encodes the register as follows. Bits [2:1] select the kind: 0 = input, 1 = output latch, 2 = polarity, 3 = direction. Bit 0 selects the port: 0 = pins [7:0], 1 = pins [15:8]. A write to indices 2 to 7 stores `wr_data` in the selected register.
- R3: A direction bit of 0 makes the pin an output: its `pin_oe` bit is 1 and its `pin_out` bit equals the output latch bit. A direction bit of 1 makes the pin an input: its `pin_oe` bit is 0 and its `pin_out` bit is 0, whatever the latch holds.
- R4: Reading an output register (index 2 or 3) returns the latch contents, not the level on the pins.
- R5: Reading an input register (index 0 or 1) returns the synchronized pin byte of that port, whatever the pin directions are.
- R6: Writes to index 0 or 1 are ignored. No register changes, `pin_oe` and `pin_out` do not change, and `in_latched` does not change.
- R7: On an input read, each bit whose polarity bit is 1 is returned inverted, and each bit whose polarity bit is 0 is returned unchanged. `in_latched` always carries the pin levels without inversion.
- R8: `rd_data` is updated on the clock edge that samples `rd_en` high. It then holds its value until the next such edge.
- R9: A read of index 0 loads `in_latched[7:0]`, and a read of index 1 loads `in_latched[15:8]`, with the synchronized pins. The other port's half does not change.
- R10: Pins pass through two flops before use. A pin change set up before edge E0 is still seen as the old level by a read sampled at edge E1. It is seen as the new level by a read sampled at edge E2.
- R11: When a read and a write to the same index fall in the same cycle, the read returns the value held before the write. The written value is returned by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| reg_idx | input | 3 | Register index (kind in [2:1], port in [0]) |
| wr_data | input | 8 | Byte to store |
| rd_data | output | 8 | Registered read byte |
| pin_in | input | 16 | Raw pin levels, asynchronous |
| pin_oe | output | 16 | Per-pin driver enable |
| pin_out | output | 16 | Per-pin driven level |
| in_latched | output | 16 | Captured input bytes for the interrupt block |

## Verification
Two functions can fall in the same cycle: a read and a write to one index, and a pin transition racing the capture strobe. The bench provokes the first by raising both strobes together on an output latch. It expects the old byte first and the new byte on the next read. It provokes the second by changing a pin one cycle before a read and again just after. It judges the result against the two-edge synchronizer delay, counted edge by edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register kind, taken from reg_idx[2:1]; reg_idx[0] picks the port.
    typedef enum logic [1:0] {
        KIND_IN  = 2'd0,
        KIND_OUT = 2'd1,
        KIND_POL = 2'd2,
        KIND_DIR = 2'd3
    } reg_kind_e;

    localparam int unsigned IDX_W = 3;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  reg_kind_e        kind,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] drive,
    output logic [WIDTH-1:0] cap,
    output logic [WIDTH-1:0] rd_val
);

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lat;
        logic [WIDTH-1:0] pol;
        logic [WIDTH-1:0] cap;
    } port_regs_t;

    port_regs_t st_d, st_q;
    logic       wr_hit, cap_hit;

    always_comb begin
        st_d    = st_q;
        wr_hit  = wr_en && sel;
        cap_hit = rd_en && sel && (kind == KIND_IN);
        if (wr_hit) begin
            unique case (kind)
                KIND_OUT: st_d.lat = wdata;
                KIND_POL: st_d.pol = wdata;
                KIND_DIR: st_d.dir = wdata;
                default:  st_d     = st_q;
            endcase
        end
        if (cap_hit) begin
            st_d.cap = pins_sync;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir <= '1;
            st_q.lat <= '1;
            st_q.pol <= '0;
            st_q.cap <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (kind)
            KIND_IN:  rd_val = pins_sync ^ st_q.pol;
            KIND_OUT: rd_val = st_q.lat;
            KIND_POL: rd_val = st_q.pol;
            default:  rd_val = st_q.dir;
        endcase
    end

    assign oe    = ~st_q.dir;
    assign drive = st_q.lat & ~st_q.dir;
    assign cap   = st_q.cap;

    // R6: an input-kind write leaves every stored register untouched
    a_r6_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel && kind == KIND_IN && !rd_en) |=> $stable(st_q))
        else $error("input-index write changed port state");

    // R9: the capture register moves only on an input read of this port
    a_r9_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && sel && kind == KIND_IN) |=> $stable(st_q.cap))
        else $error("capture changed without a read strobe");

    // R2: a direction write lands in the enables on the next cycle
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel && kind == KIND_DIR) |=> (oe == ~$past(wdata)))
        else $error("direction write not reflected on oe");

    // R3: an undriven pin never shows a driven level
    a_r3_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel && kind == KIND_DIR) |=> ((drive & ~oe) == '0))
        else $error("input pin carries a driven level");

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [IDX_W-1:0]       reg_idx,
    input  logic [PORT_W-1:0]      wr_data,
    output logic [PORT_W-1:0]      rd_data,
    input  logic [2*PORT_W-1:0]    pin_in,
    output logic [2*PORT_W-1:0]    pin_oe,
    output logic [2*PORT_W-1:0]    pin_out,
    output logic [2*PORT_W-1:0]    in_latched
);

    localparam int unsigned NPORTS = 2;
    localparam int unsigned PINS   = NPORTS * PORT_W;

    typedef struct packed {
        logic [PORT_W-1:0] rd;
    } top_regs_t;

    top_regs_t         st_d, st_q;
    logic [PINS-1:0]   pins_sync;
    logic [PORT_W-1:0] port_rd [NPORTS];
    reg_kind_e         kind;

    assign kind = reg_kind_e'(reg_idx[2:1]);

    gpio_bank_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pins_sync)
    );

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            gpio_bank_port #(
                .WIDTH (PORT_W)
            ) port_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .sel       (reg_idx[0] == 1'(p)),
                .wr_en     (wr_en),
                .rd_en     (rd_en),
                .kind      (kind),
                .wdata     (wr_data),
                .pins_sync (pins_sync[p*PORT_W +: PORT_W]),
                .oe        (pin_oe[p*PORT_W +: PORT_W]),
                .drive     (pin_out[p*PORT_W +: PORT_W]),
                .cap       (in_latched[p*PORT_W +: PORT_W]),
                .rd_val    (port_rd[p])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rd = port_rd[reg_idx[0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;

    // R8: the read byte holds while no read strobe is sampled
    a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data))
        else $error("rd_data moved without a read strobe");

    // R6: input-index writes leave the pin drive unchanged
    a_r6_pins_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == KIND_IN) |=> ($stable(pin_oe) && $stable(pin_out)))
        else $error("input-index write disturbed pin drive");

endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_oe;
    logic [15:0] pin_out;
    logic [15:0] in_latched;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .reg_idx    (reg_idx),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .pin_in     (pin_in),
        .pin_oe     (pin_oe),
        .pin_out    (pin_out),
        .in_latched (in_latched)
    );

    // {index, write byte, expected readback}
    localparam logic [18:0] VEC [6] = '{
        {3'd2, 8'hA5, 8'hA5},
        {3'd3, 8'h3C, 8'h3C},
        {3'd4, 8'h0F, 8'h0F},
        {3'd5, 8'hF0, 8'hF0},
        {3'd6, 8'h00, 8'h00},
        {3'd7, 8'hAA, 8'hAA}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] idx, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; reg_idx = idx;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] rst_exp [6] = '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rd_data", {8'h0, rd_data}, 16'h0000);
        chk("R1 pin_oe", pin_oe, 16'h0000);
        chk("R1 pin_out", pin_out, 16'h0000);
        for (int i = 0; i < 6; i++) begin
            do_read(3'(i + 2), v);
            chk("R1 reg reset", {8'h0, v}, {8'h0, rst_exp[i]});
        end

        // R2 table of writes and readbacks
        for (int i = 0; i < 6; i++) begin
            do_write(VEC[i][18:16], VEC[i][15:8]);
            do_read(VEC[i][18:16], v);
            chk("R2 write/readback", {8'h0, v}, {8'h0, VEC[i][7:0]});
        end

        // R3 direction and drive: dir0=00 out0=A5, dir1=AA out1=3C
        @(negedge clk);
        chk("R3 pin_oe", pin_oe, 16'h55FF);
        chk("R3 pin_out", pin_out, 16'h14A5);

        // R4 output readback is the latch, not the pin
        pin_in = 16'h1234;
        repeat (4) @(negedge clk);
        do_read(3'd2, v);
        chk("R4 latch readback", {8'h0, v}, 16'h00A5);

        // R5 R7 R9 input reads with polarity 0F / F0
        do_read(3'd0, v);
        chk("R5 R7 port0 read", {8'h0, v}, 16'h003B);
        chk("R9 port0 capture only", in_latched, 16'h0034);
        do_read(3'd1, v);
        chk("R5 R7 port1 read", {8'h0, v}, 16'h00E2);
        chk("R9 port1 capture", in_latched, 16'h1234);

        // R6 writes to input indices ignored
        pin_in = 16'hABCD;
        repeat (4) @(negedge clk);
        do_write(3'd0, 8'hFF);
        do_write(3'd1, 8'h00);
        @(negedge clk);
        chk("R6 in_latched kept", in_latched, 16'h1234);
        chk("R6 pin_oe kept", pin_oe, 16'h55FF);
        chk("R6 pin_out kept", pin_out, 16'h14A5);
        for (int i = 0; i < 6; i++) begin
            do_read(VEC[i][18:16], v);
            chk("R6 regs kept", {8'h0, v}, {8'h0, VEC[i][7:0]});
        end

        // R7 polarity cleared returns raw pins
        do_write(3'd4, 8'h00);
        do_read(3'd0, v);
        chk("R7 no inversion", {8'h0, v}, 16'h00CD);

        // R8 rd_data holds without strobe even as pins move
        pin_in = 16'h5566;
        repeat (4) @(negedge clk);
        chk("R8 rd_data hold", {8'h0, rd_data}, 16'h00CD);

        // R10 synchronizer delay (pin low byte 66 -> 77)
        @(negedge clk);
        pin_in = 16'h5577;
        @(negedge clk);
        rd_en = 1'b1; reg_idx = 3'd0;
        @(negedge clk);
        chk("R10 old level at E1", {8'h0, rd_data}, 16'h0066);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R10 new level at E2", {8'h0, rd_data}, 16'h0077);

        // R11 same-cycle read and write to output latch 0
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; reg_idx = 3'd2; wr_data = 8'h5A;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk("R11 old value first", {8'h0, rd_data}, 16'h00A5);
        do_read(3'd2, v);
        chk("R11 new value next", {8'h0, v}, 16'h005A);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule